// File: doc/BRIEF.md
# Core Rail Low-Power Mode Controller

This block decides when the core supply rail drops into a low-power state and when it returns. A request pin and a software enable bit are combined; only a fresh 0-to-1 transition of their AND starts low-power mode. Four separate events end the mode: the request pin falling, the enable bit clearing, a pushbutton event or a hot-reset event. Once out, the mode is entered again only after a new rising transition. A level that stays high does not bring the rail back down.

While the mode is active, the rail either moves to a preset low voltage code or, if a core-off configuration bit is set, is switched off entirely. Outside the mode the block tracks the normal voltage code and keeps a copy of it. That copy is frozen at entry, so the rail returns to the pre-entry value on exit, even if the normal code changed meanwhile. Register access and input debouncing sit outside this block. It receives clean register bits and single-cycle events.

Top module: `lpm_core_ctrl`

## Requirements
- R1: When lpReq AND lpEnable goes from 0 (value at the previous clock edge) to 1, lpActive becomes 1 after that clock edge.
- R2: While lpEnable is 0, any activity on lpReq leaves lpActive at 0.
- R3: After an exit, lpReq and lpEnable held high without a new 0-to-1 transition of their AND do not set lpActive again.
- R4: While lpActive is 1, lpReq or lpEnable being 0 at a clock edge clears lpActive after that edge.
- R5: While lpActive is 1, a one-cycle buttonEvt or hotResetEvt pulse clears lpActive after that edge.
- R6: When buttonEvt or hotResetEvt is 1 in the same cycle as an entry transition, lpActive stays 0.
- R7: After a pushbutton exit with lpReq held high, the mode is re-entered by dropping and re-raising lpReq, or by dropping and re-raising lpEnable.
- R8: With lpActive 1 and coreOffCfg 0, coreSelLow is 1, coreDisable is 0 and coreCode equals presetCode. With lpActive 1 and coreOffCfg 1, coreDisable is 1 and coreSelLow is 0.
- R9: Outside the mode, coreCode equals normCode as sampled at the previous clock edge. On exit, coreCode shows the normCode sampled at the last edge before entry, then resumes tracking normCode one cycle later.
- R10: After reset, lpActive, coreSelLow and coreDisable are 0 and coreCode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lpReq | input | 1 | Low-power request pin level |
| lpEnable | input | 1 | Register bit that allows low-power mode |
| coreOffCfg | input | 1 | Register bit: switch the rail off instead of lowering it |
| buttonEvt | input | 1 | Single-cycle pushbutton event |
| hotResetEvt | input | 1 | Single-cycle hot-reset event |
| normCode | input | CODE_W | Normal core voltage code |
| presetCode | input | CODE_W | Preset low core voltage code |
| lpActive | output | 1 | Low-power mode active |
| coreSelLow | output | 1 | Rail uses the preset low code |
| coreDisable | output | 1 | Rail switched off |
| coreCode | output | CODE_W | Voltage code driven to the rail regulator |

## Verification
The assertions assume that buttonEvt and hotResetEvt are clean synchronous pulses, and that every input settles well before each clock edge. The bench drives all inputs on the falling edge and raises each event for exactly one cycle. It never depends on metastability or glitch behaviour. Before each scenario it returns lpReq and lpEnable to 0 for a cycle, so the registered copy of their AND starts from a known level.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef struct packed {
    logic capture;   // track normal code into the saved register
    logic useLow;    // rail on preset low code
    logic coreOff;   // rail switched off
  } lpStrobes_t;
endpackage

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpReq,
  input  logic       lpEnable,
  input  logic       coreOffCfg,
  input  logic       buttonEvt,
  input  logic       hotResetEvt,
  output logic       lpActive,
  output lpStrobes_t strobes
);
  logic gateNow;
  logic armQ;
  logic inLpQ;
  logic riseSeen;
  logic eventExit;
  logic levelExit;

  assign gateNow   = lpReq & lpEnable;
  assign riseSeen  = gateNow & ~armQ;
  assign eventExit = buttonEvt | hotResetEvt;
  assign levelExit = ~gateNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ  <= 1'b0;
      inLpQ <= 1'b0;
    end else begin
      armQ <= gateNow;
      if (inLpQ) begin
        if (levelExit || eventExit) inLpQ <= 1'b0;
      end else if (riseSeen && !eventExit) begin
        inLpQ <= 1'b1;
      end
    end
  end

  assign lpActive        = inLpQ;
  assign strobes.capture = ~inLpQ;
  assign strobes.useLow  = inLpQ & ~coreOffCfg;
  assign strobes.coreOff = inLpQ & coreOffCfg;

  p_enter_on_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!inLpQ && gateNow && !armQ && !eventExit) |=> inLpQ);
  p_enable_gates_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!inLpQ && !lpEnable) |=> !inLpQ);
  p_level_no_reentry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!inLpQ && armQ) |=> !inLpQ);
  p_level_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inLpQ && (!lpReq || !lpEnable)) |=> !inLpQ);
  p_event_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inLpQ && eventExit) |=> !inLpQ);
  p_exit_priority_r6: assert property (@(posedge clk) disable iff (!rstN)
    eventExit |=> !inLpQ);
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStrobes_t        strobes,
  input  logic [CODE_W-1:0] normCode,
  input  logic [CODE_W-1:0] presetCode,
  output logic              coreSelLow,
  output logic              coreDisable,
  output logic [CODE_W-1:0] coreCode
);
  logic [CODE_W-1:0] savedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               savedQ <= '0;
    else if (strobes.capture) savedQ <= normCode;
  end

  assign coreSelLow  = strobes.useLow;
  assign coreDisable = strobes.coreOff;
  assign coreCode    = strobes.useLow ? presetCode : savedQ;

  p_hold_in_lp_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(savedQ));
  p_track_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (savedQ == $past(normCode)));
  p_rail_mode_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(coreSelLow && coreDisable));
endmodule

// File: rtl/lpm_core_ctrl.sv
module lpm_core_ctrl
  import lpm_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpReq,
  input  logic              lpEnable,
  input  logic              coreOffCfg,
  input  logic              buttonEvt,
  input  logic              hotResetEvt,
  input  logic [CODE_W-1:0] normCode,
  input  logic [CODE_W-1:0] presetCode,
  output logic              lpActive,
  output logic              coreSelLow,
  output logic              coreDisable,
  output logic [CODE_W-1:0] coreCode
);
  lpStrobes_t strobes;

  lpm_control uCtrl (
    .clk(clk), .rstN(rstN), .lpReq(lpReq), .lpEnable(lpEnable),
    .coreOffCfg(coreOffCfg), .buttonEvt(buttonEvt), .hotResetEvt(hotResetEvt),
    .lpActive(lpActive), .strobes(strobes)
  );

  lpm_datapath #(.CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .normCode(normCode),
    .presetCode(presetCode), .coreSelLow(coreSelLow),
    .coreDisable(coreDisable), .coreCode(coreCode)
  );

  p_reset_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!lpActive && !coreDisable));
endmodule

// File: tb/tb_lpm_core_ctrl.sv
module tb_lpm_core_ctrl;
  localparam int CODE_W = 6;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lpReq = 1'b0, lpEnable = 1'b0, coreOffCfg = 1'b0;
  logic buttonEvt = 1'b0, hotResetEvt = 1'b0;
  logic [CODE_W-1:0] normCode = '0, presetCode = 6'd5;
  logic lpActive, coreSelLow, coreDisable;
  logic [CODE_W-1:0] coreCode;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lpm_core_ctrl #(.CODE_W(CODE_W)) dut (
    .clk(clk), .rstN(rstN), .lpReq(lpReq), .lpEnable(lpEnable),
    .coreOffCfg(coreOffCfg), .buttonEvt(buttonEvt), .hotResetEvt(hotResetEvt),
    .normCode(normCode), .presetCode(presetCode), .lpActive(lpActive),
    .coreSelLow(coreSelLow), .coreDisable(coreDisable), .coreCode(coreCode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    lpReq = 0; lpEnable = 0; buttonEvt = 0; hotResetEvt = 0; coreOffCfg = 0;
    step(2);
  endtask

  task automatic enter();
    lpReq = 1; lpEnable = 1; step(1);
  endtask

  task automatic t_reset();
    chk(lpActive == 0, "R10 lpActive", lpActive, 0);
    chk(coreDisable == 0 && coreSelLow == 0, "R10 rail flags", {coreDisable, coreSelLow}, 0);
    chk(coreCode == 0, "R10 coreCode", coreCode, 0);
  endtask

  task automatic t_entry_and_rail();
    idle(); normCode = 6'd12; step(1);
    enter();
    chk(lpActive == 1, "R1 entry on rise", lpActive, 1);
    chk(coreSelLow == 1 && coreDisable == 0, "R8 lowered", {coreSelLow, coreDisable}, 2);
    chk(coreCode == presetCode, "R8 preset code", coreCode, presetCode);
    coreOffCfg = 1; step(1);
    chk(coreDisable == 1 && coreSelLow == 0, "R8 core off", {coreDisable, coreSelLow}, 2);
    lpReq = 0; step(1);
    chk(lpActive == 0, "R4 exit on req low", lpActive, 0);
    coreOffCfg = 0;
  endtask

  task automatic t_enable_gate();
    idle();
    lpReq = 1; step(1); lpReq = 0; step(1); lpReq = 1; step(2);
    chk(lpActive == 0, "R2 req ignored", lpActive, 0);
    enter(); lpEnable = 0; step(1);
    chk(lpActive == 0, "R4 exit on enable low", lpActive, 0);
  endtask

  task automatic t_event_exits();
    idle(); enter();
    hotResetEvt = 1; step(1); hotResetEvt = 0;
    chk(lpActive == 0, "R5 hot reset exit", lpActive, 0);
    step(3);
    chk(lpActive == 0, "R3 held level no reentry", lpActive, 0);
    idle(); enter();
    buttonEvt = 1; step(1); buttonEvt = 0;
    chk(lpActive == 0, "R5 button exit", lpActive, 0);
  endtask

  task automatic t_priority();
    idle();
    lpReq = 1; lpEnable = 1; buttonEvt = 1; step(1); buttonEvt = 0;
    chk(lpActive == 0, "R6 exit wins", lpActive, 0);
    step(1);
    chk(lpActive == 0, "R6 no late entry", lpActive, 0);
  endtask

  task automatic t_reentry();
    idle(); enter();
    buttonEvt = 1; step(1); buttonEvt = 0; step(1);
    lpReq = 0; step(1); lpReq = 1; step(1);
    chk(lpActive == 1, "R7 reentry via req toggle", lpActive, 1);
    buttonEvt = 1; step(1); buttonEvt = 0; step(1);
    lpEnable = 0; step(1); lpEnable = 1; step(1);
    chk(lpActive == 1, "R7 reentry via enable toggle", lpActive, 1);
  endtask

  task automatic t_restore();
    idle(); normCode = 6'd17; step(1);
    chk(coreCode == 17, "R9 tracking", coreCode, 17);
    enter();
    normCode = 6'd33; step(2);
    buttonEvt = 1; step(1); buttonEvt = 0;
    chk(coreCode == 17, "R9 restore saved", coreCode, 17);
    step(1);
    chk(coreCode == 33, "R9 resume tracking", coreCode, 33);
  endtask

  initial begin
    fork
      begin
        step(2); rstN = 1; step(1);
        t_reset();
        t_entry_and_rail();
        t_enable_gate();
        t_event_exits();
        t_priority();
        t_reentry();
        t_restore();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule